// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers the data bytes of one memory write sequence into a page-sized staging buffer, then programs them into a word-organised non-volatile array during a timed write cycle. A protocol engine in front of it supplies strobes. A load strobe opens a sequence: it fixes the page and the starting byte offset and forgets any bytes loaded earlier. Byte strobes each deposit one byte and step the offset. The offset wraps inside the fixed page. A commit strobe starts programming. An abort strobe throws the sequence away, for example when a write was refused or no data arrived.

The array is programmed in words of `WORD_BYTES` bytes, and each word carries check bits from an external codec. For every word that holds at least one loaded byte, the controller reads the stored word and overlays the new bytes on it. It passes the merged word to the codec and writes the word back together with the returned check bits. Words with no loaded byte are never touched. `busy_o` stays high for exactly `WR_CYCLES` clock cycles per accepted commit. While it is high the block ignores every strobe.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After synchronous reset `busy_o`, `mem_we_o` and `mem_rd_en_o` are 0.
- R2: A load strobe fixes the page (address bits above the in-page offset) for the sequence. Each byte strobe advances the in-page offset by one, and the offset goes from `PAGE_BYTES-1` back to 0 within the same page.
- R3: When two bytes of one sequence land on the same offset, the array receives the later one.
- R4: Only bytes loaded since the most recent load strobe are programmed. Bytes discarded by a load or an abort never reach the array.
- R5: Each programmed word is written once per commit. A word is `WORD_BYTES` bytes, and data lane l (bits 8l+7..8l) holds the byte at word offset l. Loaded bytes take the new value and the other lanes keep the value read from the array at that word.
- R6: `mem_wr_chk_o` equals the `enc_chk_i` value that the codec returns for the written word, which is presented on `enc_data_o`.
- R7: An accepted commit raises `busy_o` from the next cycle for exactly `WR_CYCLES` cycles, and array writes occur only while `busy_o` is high.
- R8: A word with no loaded byte is not written, so the number of writes per commit equals the number of words holding a loaded byte.
- R9: An abort strobe, or a commit while no byte is loaded, leaves `busy_o` low and writes nothing.
- R10: Load, byte, commit and abort strobes that arrive while `busy_o` is high have no effect.
- R11: Every array write address lies in the page fixed by the sequence's load strobe. The word address is the page number followed by the word index within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Start a sequence at `ld_addr_i` |
| ld_addr_i | input | ADDR_W | Byte address: page above, offset below |
| wr_i | input | 1 | Deposit `wr_data_i` at the current offset |
| wr_data_i | input | 8 | Byte to deposit |
| commit_i | input | 1 | Program the loaded bytes |
| abort_i | input | 1 | Discard the loaded bytes |
| busy_o | output | 1 | Write cycle in progress |
| mem_rd_en_o | output | 1 | Array read request (data one cycle later) |
| mem_rd_addr_o | output | ADDR_W-log2(WORD_BYTES) | Array word read address |
| mem_rd_data_i | input | 8*WORD_BYTES | Array read data |
| mem_we_o | output | 1 | Array word write enable |
| mem_wr_addr_o | output | ADDR_W-log2(WORD_BYTES) | Array word write address |
| mem_wr_data_o | output | 8*WORD_BYTES | Merged word to store |
| mem_wr_chk_o | output | CHK_W | Check bits to store |
| enc_data_o | output | 8*WORD_BYTES | Merged word presented to the codec |
| enc_chk_i | input | CHK_W | Check bits returned by the codec |

## Verification
The bench keeps the default 14-bit address, 64-byte page, 4-byte word and 6-bit check field. It lowers `WR_CYCLES` to 60, just above the 3·16+2 cycles a full-page merge needs. That keeps every write cycle short enough for dozens of random sequences in one run. Those sequences still wrap the offset several times, hit pages that already hold data, and make the merge scan all sixteen words.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_RDW,
    S_MRG,
    S_HOLD
  } seq_st_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store
  import pgbuf_pkg::*;
#(
  parameter  int ADDR_W     = 14,
  parameter  int PAGE_BYTES = 64,
  parameter  int WORD_BYTES = 4,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFF_W,
  localparam int LANE_W     = $clog2(WORD_BYTES),
  localparam int WORDS      = PAGE_BYTES / WORD_BYTES,
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic                  wr,
  input  byte_t                 wr_data,
  input  logic                  clr,
  input  logic [WIDX_W-1:0]     rd_idx,
  output logic [WORD_W-1:0]     rd_word,
  output logic [WORD_BYTES-1:0] grp_mask,
  output logic                  any_valid,
  output logic [PAGE_W-1:0]     page
);
  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      off_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [WORD_W-1:0]     buf_mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (ld) begin
      page_q <= ld_addr[ADDR_W-1:OFF_W];
      off_q  <= ld_addr[OFF_W-1:0];
      mask_q <= '0;
    end else if (wr) begin
      mask_q[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1;
    end
  end

  // byte-lane write into a word-wide RAM, registered read
  always_ff @(posedge clk) begin
    if (wr && !ld && !clr) begin
      for (int l = 0; l < WORD_BYTES; l++) begin
        if (off_q[LANE_W-1:0] == LANE_W'(l))
          buf_mem[off_q[OFF_W-1:LANE_W]][l*8 +: 8] <= wr_data;
      end
    end
    rd_word <= buf_mem[rd_idx];
  end

  assign grp_mask  = mask_q[rd_idx*WORD_BYTES +: WORD_BYTES];
  assign any_valid = |mask_q;
  assign page      = page_q;

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && !ld && !clr && off_q == OFF_W'(PAGE_BYTES-1)) |=> (off_q == '0));
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld) |=> $stable(page_q));
  assert_clr_empties_R4: assert property (@(posedge clk) disable iff (rst)
    (clr || ld) |=> !any_valid);
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter  int WORDS      = 16,
  parameter  int WORD_BYTES = 4,
  parameter  int PAGE_W     = 8,
  parameter  int CHK_W      = 6,
  parameter  int WR_CYCLES  = 250000,
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int WORD_W     = 8 * WORD_BYTES,
  localparam int WADDR_W    = PAGE_W + WIDX_W,
  localparam int CNT_W      = $clog2(WR_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [PAGE_W-1:0]     page,
  input  logic [WORD_BYTES-1:0] grp_mask,
  input  logic [WORD_W-1:0]     buf_word,
  input  logic [WORD_W-1:0]     mem_rd_data,
  input  logic [CHK_W-1:0]      enc_chk,
  output logic [WIDX_W-1:0]     idx,
  output logic                  busy,
  output logic                  clr,
  output logic                  mem_rd_en,
  output logic [WADDR_W-1:0]    mem_rd_addr,
  output logic                  mem_we,
  output logic [WADDR_W-1:0]    mem_wr_addr,
  output logic [WORD_W-1:0]     mem_wr_data,
  output logic [CHK_W-1:0]      mem_wr_chk,
  output logic [WORD_W-1:0]     enc_data
);
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(WORDS - 1);
  localparam logic [CNT_W-1:0]  CEND = CNT_W'(WR_CYCLES - 1);

  seq_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WORD_W-1:0]  merged;

  always_comb begin
    for (int l = 0; l < WORD_BYTES; l++)
      merged[l*8 +: 8] = grp_mask[l] ? buf_word[l*8 +: 8] : mem_rd_data[l*8 +: 8];
  end
  assign enc_data = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      idx         <= '0;
      busy        <= 1'b0;
      cnt_q       <= '0;
      clr         <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_we      <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      mem_wr_chk  <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_we    <= 1'b0;
      clr       <= 1'b0;
      if (busy) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CEND) busy <= 1'b0;
      end
      case (st_q)
        S_IDLE: if (start) begin
          busy  <= 1'b1;
          cnt_q <= '0;
          idx   <= '0;
          st_q  <= S_SCAN;
        end
        S_SCAN: begin
          if (|grp_mask) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {page, idx};
            st_q        <= S_RDW;
          end else if (idx == LAST) begin
            clr  <= 1'b1;
            st_q <= S_HOLD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RDW: st_q <= S_MRG;
        S_MRG: begin
          mem_we      <= 1'b1;
          mem_wr_addr <= {page, idx};
          mem_wr_data <= merged;
          mem_wr_chk  <= enc_chk;
          if (idx == LAST) begin
            clr  <= 1'b1;
            st_q <= S_HOLD;
          end else begin
            idx  <= idx + 1'b1;
            st_q <= S_SCAN;
          end
        end
        S_HOLD: if (cnt_q == CEND) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_busy_span_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt_q) == CEND));
  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_rd_en, 2));
  assert_one_access_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_rd_en));
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter  int ADDR_W     = 14,
  parameter  int PAGE_BYTES = 64,
  parameter  int WORD_BYTES = 4,
  parameter  int CHK_W      = 6,
  parameter  int WR_CYCLES  = 250000,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFF_W,
  localparam int WORDS      = PAGE_BYTES / WORD_BYTES,
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int WADDR_W    = PAGE_W + WIDX_W,
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic               wr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               commit_i,
  input  logic               abort_i,
  output logic               busy_o,
  output logic               mem_rd_en_o,
  output logic [WADDR_W-1:0] mem_rd_addr_o,
  input  logic [WORD_W-1:0]  mem_rd_data_i,
  output logic               mem_we_o,
  output logic [WADDR_W-1:0] mem_wr_addr_o,
  output logic [WORD_W-1:0]  mem_wr_data_o,
  output logic [CHK_W-1:0]   mem_wr_chk_o,
  output logic [WORD_W-1:0]  enc_data_o,
  input  logic [CHK_W-1:0]   enc_chk_i
);
  logic                  idle, any_valid, seq_clr, st_clr, start;
  logic [WIDX_W-1:0]     idx;
  logic [WORD_W-1:0]     buf_word;
  logic [WORD_BYTES-1:0] grp_mask;
  logic [PAGE_W-1:0]     page;

  assign idle   = !busy_o;
  assign start  = commit_i && idle && !abort_i && any_valid;
  assign st_clr = seq_clr || (abort_i && idle);

  pgbuf_store #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_store (
    .clk(clk), .rst(rst),
    .ld(ld_i && idle), .ld_addr(ld_addr_i),
    .wr(wr_i && idle), .wr_data(wr_data_i),
    .clr(st_clr), .rd_idx(idx), .rd_word(buf_word),
    .grp_mask(grp_mask), .any_valid(any_valid), .page(page)
  );

  pgbuf_seq #(
    .WORDS(WORDS), .WORD_BYTES(WORD_BYTES), .PAGE_W(PAGE_W),
    .CHK_W(CHK_W), .WR_CYCLES(WR_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .page(page),
    .grp_mask(grp_mask), .buf_word(buf_word), .mem_rd_data(mem_rd_data_i),
    .enc_chk(enc_chk_i), .idx(idx), .busy(busy_o), .clr(seq_clr),
    .mem_rd_en(mem_rd_en_o), .mem_rd_addr(mem_rd_addr_o),
    .mem_we(mem_we_o), .mem_wr_addr(mem_wr_addr_o),
    .mem_wr_data(mem_wr_data_o), .mem_wr_chk(mem_wr_chk_o),
    .enc_data(enc_data_o)
  );

  assert_we_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
  assert_empty_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (commit_i && idle && !any_valid) |=> !busy_o);
  assert_write_in_page_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wr_addr_o[WADDR_W-1 -: PAGE_W] == page));
  assert_chk_from_codec_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wr_chk_o == $past(enc_chk_i)));
endmodule

// File: tb/pgbuf_ctrl_bench.sv
module pgbuf_ctrl_bench;
  localparam int WRC = 60;

  logic        clk = 0, rst = 1;
  logic        ld = 0, wr = 0, commit = 0, abort = 0;
  logic [13:0] ld_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy, rd_en, we;
  logic [11:0] rd_addr, wr_addr;
  logic [31:0] rd_data = '0, wr_word, enc_data;
  logic [5:0]  wr_chk, enc_chk;

  always #10 clk = ~clk;

  pgbuf_ctrl #(.WR_CYCLES(WRC)) u_pgbuf_ctrl (
    .clk(clk), .rst(rst), .ld_i(ld), .ld_addr_i(ld_addr), .wr_i(wr),
    .wr_data_i(wr_data), .commit_i(commit), .abort_i(abort), .busy_o(busy),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_we_o(we), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_word),
    .mem_wr_chk_o(wr_chk), .enc_data_o(enc_data), .enc_chk_i(enc_chk)
  );

  function automatic logic [5:0] chkf(input logic [31:0] d);
    for (int i = 0; i < 6; i++) chkf[i] = ^(d & (32'h9E37_79B9 >> i)) ^ d[31-i];
  endfunction
  assign enc_chk = chkf(enc_data);

  // array model and bench expectation, erased = FFh
  logic [7:0] mb [int];
  logic [5:0] mc [int];
  logic [7:0] sm [int];
  int         nwrites, badpage, exp_page;
  int         nchecks = 0, nfails = 0;

  function automatic logic [7:0] mrd(input int a);
    return mb.exists(a) ? mb[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] srd(input int a);
    return sm.exists(a) ? sm[a] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (rd_en)
      for (int l = 0; l < 4; l++) rd_data[l*8 +: 8] <= mrd(int'(rd_addr)*4 + l);
    if (we) begin
      for (int l = 0; l < 4; l++) mb[int'(wr_addr)*4 + l] = wr_word[l*8 +: 8];
      mc[int'(wr_addr)] = wr_chk;
      nwrites++;
      if (int'(wr_addr[11:4]) != exp_page) badpage++;
    end
  end

  // bench view of the sequence
  int         s_page, s_off;
  bit         s_v [64];
  logic [7:0] s_b [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int a, input bit acc);
    ld = 1; ld_addr = 14'(a);
    @(negedge clk); ld = 0;
    if (acc) begin
      s_page = a / 64; s_off = a % 64;
      foreach (s_v[i]) s_v[i] = 0;
    end
  endtask

  task automatic do_byte(input logic [7:0] d, input bit acc);
    wr = 1; wr_data = d;
    @(negedge clk); wr = 0;
    if (acc) begin
      s_b[s_off] = d; s_v[s_off] = 1; s_off = (s_off + 1) % 64;
    end
  endtask

  task automatic do_abort();
    abort = 1; @(negedge clk); abort = 0;
    foreach (s_v[i]) s_v[i] = 0;
    check(busy == 0, "R9 abort busy", busy, 0);
  endtask

  // commit and verify the whole page
  task automatic do_commit();
    int exp_w, len, bad, fa, fe;
    bit any;
    exp_w = 0; any = 0;
    for (int w = 0; w < 16; w++) begin
      bit t = 0;
      for (int l = 0; l < 4; l++) t |= s_v[w*4+l];
      if (t) exp_w++;
    end
    any = (exp_w != 0);
    for (int i = 0; i < 64; i++)
      if (s_v[i]) sm[s_page*64 + i] = s_b[i];
    nwrites = 0; badpage = 0; exp_page = s_page;
    commit = 1; @(negedge clk); commit = 0;
    if (!any) begin
      check(busy == 0, "R9 empty commit busy", busy, 0);
      repeat (3) @(negedge clk);
      check(nwrites == 0, "R9 empty commit writes", nwrites, 0);
    end else begin
      len = 0;
      while (busy && len < 4*WRC) begin len++; @(negedge clk); end
      check(len == WRC, "R7 busy length", len, WRC);
      check(nwrites == exp_w, "R8 write count", nwrites, exp_w);
      check(badpage == 0, "R11 write outside page", badpage, 0);
      bad = 0; fa = 0; fe = 0;
      for (int i = 0; i < 64; i++) begin
        int a = s_page*64 + i;
        if (mrd(a) !== srd(a)) begin
          if (bad == 0) begin fa = mrd(a); fe = srd(a); end
          bad++;
        end
      end
      check(bad == 0, "R3/R4/R5 page contents", fa, fe);
      bad = 0;
      for (int w = 0; w < 16; w++) begin
        int wa = s_page*16 + w;
        if (mc.exists(wa)) begin
          logic [31:0] d;
          for (int l = 0; l < 4; l++) d[l*8 +: 8] = mrd(wa*4 + l);
          if (mc[wa] !== chkf(d)) bad++;
        end
      end
      check(bad == 0, "R6 check bits", bad, 0);
    end
    foreach (s_v[i]) s_v[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfails++; nchecks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchecks, nfails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234);
    foreach (s_v[i]) s_v[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(we == 0, "R1 write enable after reset", we, 0);
    check(rd_en == 0, "R1 read enable after reset", rd_en, 0);

    // R2/R3: start near page end, wrap and overwrite
    do_load(5*64 + 60, 1);
    for (int i = 0; i < 70; i++) do_byte(8'(i ^ 8'h3C), 1);
    do_commit();

    // R5/R8: fill a page, then change two bytes of one word
    do_load(9*64, 1);
    for (int i = 0; i < 64; i++) do_byte(8'(8'hA0 + i), 1);
    do_commit();
    do_load(9*64 + 5, 1);
    do_byte(8'h11, 1); do_byte(8'h22, 1);
    do_commit();

    // R4: aborted bytes and bytes before a reload stay out of the array
    do_load(12*64, 1);
    for (int i = 0; i < 8; i++) do_byte(8'h55, 1);
    do_abort();
    do_load(12*64 + 40, 1);
    do_byte(8'h77, 1);
    do_load(12*64 + 32, 1);
    for (int i = 0; i < 4; i++) do_byte(8'(8'hC0 + i), 1);
    do_commit();

    // R9: load with no data
    do_load(20*64 + 3, 1);
    do_commit();

    // R10: strobes during the write cycle are ignored
    do_load(30*64, 1);
    do_byte(8'h5A, 1);
    nwrites = 0; badpage = 0; exp_page = 30;
    sm[30*64] = 8'h5A;
    commit = 1; @(negedge clk); commit = 0;
    do_load(31*64, 0);
    do_byte(8'hE1, 0); do_byte(8'hE2, 0);
    abort = 1; @(negedge clk); abort = 0;
    commit = 1; @(negedge clk); commit = 0;
    while (busy) @(negedge clk);
    check(nwrites == 1, "R10 writes during busy", nwrites, 1);
    check(mrd(31*64) == 8'hFF, "R10 ignored byte stored", mrd(31*64), 8'hFF);
    foreach (s_v[i]) s_v[i] = 0;
    s_page = 30;
    do_commit();
    check(mrd(30*64) == 8'h5A, "R10 first commit kept", mrd(30*64), 8'h5A);

    // random sequences
    for (int n = 0; n < 30; n++) begin
      int pg, cnt, kind;
      pg = $urandom_range(0, 7) + 40;
      kind = $urandom_range(0, 9);
      do_load(pg*64 + $urandom_range(0, 63), 1);
      cnt = $urandom_range(1, 80);
      for (int i = 0; i < cnt; i++) do_byte(8'($urandom), 1);
      if (kind == 0) begin
        do_abort();
        do_commit();
      end else begin
        do_commit();
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchecks, nfails);
    $finish;
  end
endmodule